// File: doc/BRIEF.md
# Age-Ordered Crossbar Target Arbiter

This block is the switching core for one direction of a non-blocking crossbar. Eight sources each present a request that names one of nine targets and carries a 64-bit payload. Each target keeps its own arrival-ordered list of waiting sources and releases the oldest one per cycle. All targets work side by side, so distinct source/target pairs move in the same cycle.

Every request passes through three registered steps: capture, enqueue into the target's age list, and grant. In the grant cycle the target output shows a valid bit, the source number and the payload. The source sees a one-cycle grant pulse in that same cycle. The source side is a valid/hold handshake. A source raises `src_valid` with a stable target index and payload and holds all three until its `src_grant` (or `src_err`) pulse. It may start a new request from the following cycle. Targets apply no back-pressure: a target output is valid for exactly the one cycle of the grant. A source has at most one request in flight.

Top module: `xbar_age_arb`

## Requirements
- R1: While and right after reset, `src_grant`, `src_err` and `dst_valid` are all zero.
- R2: A request first presented in cycle t to an idle target is granted in cycle t+3: `src_grant[s]` and `dst_valid[d]` are high together in that cycle.
- R3: In a grant cycle, `dst_src[d]` holds the granted source number and `dst_data[d]` holds the payload that source presented with the request.
- R4: Among sources waiting for one target, the one whose request was captured earliest is granted first, regardless of source number. A target grants at most one source per cycle, and waiting sources are granted in back-to-back cycles.
- R5: Requests captured in the same cycle for one target are granted in ascending source-number order.
- R6: Requests from different sources to different targets presented in the same cycle are all granted in the same cycle.
- R7: A request held after capture is never captured twice: each request yields exactly one grant. A new request presented in the cycle after a grant is granted three cycles later, when its target is idle.
- R8: A request whose target index is 9 or above (index width 4 bits) is dropped. It raises `src_err[s]` for exactly one cycle, in cycle t+1. It produces no grant and no target output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| src_valid | input | 8 | Per-source request valid, held until grant or error |
| src_dst | input | 32 | Per-source target index, 4 bits per source, source s at [4s+3:4s] |
| src_data | input | 512 | Per-source payload, 64 bits per source |
| src_grant | output | 8 | Per-source one-cycle grant pulse |
| src_err | output | 8 | Per-source one-cycle pulse for an out-of-range target |
| dst_valid | output | 9 | Per-target transfer valid, one cycle per grant |
| dst_src | output | 27 | Per-target granted source number, 3 bits per target |
| dst_data | output | 576 | Per-target payload, 64 bits per target |

## Verification
Every result has a fixed due cycle counted from the cycle a request is first sampled. An error pulse is due one cycle later. A grant to an idle target is due three cycles later. Each further waiter in a target's list is due one cycle after the one ahead of it. The bench computes those cycle numbers when it issues a request and stores them in a scoreboard. It samples outputs on the falling clock edge, so each entry is matched against the exact cycle. Any output that arrives early, late, or without a matching entry is reported.

// File: rtl/xbar_pkg.sv
package xbar_pkg;
  localparam int unsigned XB_SOURCES = 8;
  localparam int unsigned XB_TARGETS = 9;
  localparam int unsigned XB_PAYLOAD = 64;

  function automatic int unsigned xb_idx_w(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/xbar_src_stage.sv
module xbar_src_stage #(
  parameter int unsigned ND   = 9,
  parameter int unsigned DSTW = 4,
  parameter int unsigned DW   = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            valid,
  input  logic [DSTW-1:0] dst,
  input  logic [DW-1:0]   data,
  input  logic            granted,
  output logic            cap_new,
  output logic [DSTW-1:0] cap_dst,
  output logic [DW-1:0]   pay,
  output logic            err
);
  localparam logic [DSTW:0] LIM = (DSTW+1)'(ND);

  logic busy, cap_vld, bad;
  logic accept;

  assign accept  = valid && !busy;
  assign err     = cap_vld && bad;
  assign cap_new = cap_vld && !bad;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      cap_vld <= 1'b0;
      bad     <= 1'b0;
      cap_dst <= '0;
      pay     <= '0;
    end else begin
      cap_vld <= accept;
      if (accept) begin
        cap_dst <= dst;
        pay     <= data;
        bad     <= ({1'b0, dst} >= LIM);
        busy    <= 1'b1;
      end else if (granted || err) begin
        busy    <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/xbar_dst_queue.sv
module xbar_dst_queue #(
  parameter int unsigned NS   = 8,
  parameter int unsigned SRCW = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NS-1:0]   arrive,
  output logic            gnt_vld,
  output logic [SRCW-1:0] gnt_src
);
  localparam int unsigned CW = $clog2(NS + 1);
  localparam logic [CW-1:0] ONE = CW'(1);
  localparam logic [CW-1:0] CAP = CW'(NS);

  logic [NS-1:0][SRCW-1:0] q, nq;
  logic [CW-1:0] cnt, pos;
  logic pop;

  always_comb begin
    pop = (cnt != '0);
    nq  = q;
    pos = cnt;
    if (pop) begin
      for (int k = 0; k < NS - 1; k++) nq[k] = q[k+1];
      nq[NS-1] = '0;
      pos = cnt - ONE;
    end
    for (int i = 0; i < NS; i++) begin
      if (arrive[i] && (pos < CAP)) begin
        nq[pos[SRCW-1:0]] = SRCW'(i);
        pos = pos + ONE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q       <= '0;
      cnt     <= '0;
      gnt_vld <= 1'b0;
      gnt_src <= '0;
    end else begin
      q       <= nq;
      cnt     <= pos;
      gnt_vld <= pop;
      gnt_src <= q[0];
    end
  end
endmodule

// File: rtl/xbar_age_arb.sv
module xbar_age_arb #(
  parameter int unsigned NS   = xbar_pkg::XB_SOURCES,
  parameter int unsigned ND   = xbar_pkg::XB_TARGETS,
  parameter int unsigned DW   = xbar_pkg::XB_PAYLOAD,
  parameter int unsigned DSTW = $clog2(ND + 1),
  parameter int unsigned SRCW = xbar_pkg::xb_idx_w(NS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NS-1:0]      src_valid,
  input  logic [NS*DSTW-1:0] src_dst,
  input  logic [NS*DW-1:0]   src_data,
  output logic [NS-1:0]      src_grant,
  output logic [NS-1:0]      src_err,
  output logic [ND-1:0]      dst_valid,
  output logic [ND*SRCW-1:0] dst_src,
  output logic [ND*DW-1:0]   dst_data
);
  logic [NS-1:0]           cap_new;
  logic [NS-1:0][DSTW-1:0] cap_dst;
  logic [NS-1:0][DW-1:0]   pay;
  logic [ND-1:0][NS-1:0]   arrive;
  logic [ND-1:0][SRCW-1:0] gsrc;

  for (genvar s = 0; s < NS; s++) begin : g_src
    xbar_src_stage #(.ND(ND), .DSTW(DSTW), .DW(DW)) i_stage (
      .clk     (clk),
      .rst_n   (rst_n),
      .valid   (src_valid[s]),
      .dst     (src_dst[s*DSTW +: DSTW]),
      .data    (src_data[s*DW +: DW]),
      .granted (src_grant[s]),
      .cap_new (cap_new[s]),
      .cap_dst (cap_dst[s]),
      .pay     (pay[s]),
      .err     (src_err[s])
    );
  end

  for (genvar d = 0; d < ND; d++) begin : g_dst
    for (genvar s = 0; s < NS; s++) begin : g_hit
      assign arrive[d][s] = cap_new[s] && (cap_dst[s] == DSTW'(d));
    end
    xbar_dst_queue #(.NS(NS), .SRCW(SRCW)) i_queue (
      .clk     (clk),
      .rst_n   (rst_n),
      .arrive  (arrive[d]),
      .gnt_vld (dst_valid[d]),
      .gnt_src (gsrc[d])
    );
    assign dst_src[d*SRCW +: SRCW] = gsrc[d];
    assign dst_data[d*DW +: DW]    = pay[gsrc[d]];
  end

  always_comb begin
    src_grant = '0;
    for (int d = 0; d < ND; d++) begin
      if (dst_valid[d]) src_grant[gsrc[d]] = 1'b1;
    end
  end
endmodule

// File: rtl/xbar_age_arb_chk.sv
module xbar_age_arb_chk #(
  parameter int unsigned NS   = 8,
  parameter int unsigned ND   = 9,
  parameter int unsigned DW   = 64,
  parameter int unsigned DSTW = 4,
  parameter int unsigned SRCW = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NS-1:0]      src_valid,
  input logic [NS*DSTW-1:0] src_dst,
  input logic [NS*DW-1:0]   src_data,
  input logic [NS-1:0]      src_grant,
  input logic [NS-1:0]      src_err,
  input logic [ND-1:0]      dst_valid,
  input logic [ND*SRCW-1:0] dst_src,
  input logic [ND*DW-1:0]   dst_data
);
  // R6, R7: each target grant maps to a distinct source grant
  a_r6_grant_count: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(dst_valid) == $countones(src_grant));

  // R8: an errored request is never granted
  a_r8_err_no_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (src_err & src_grant) == '0);

  for (genvar s = 0; s < NS; s++) begin : g_chk
    // R8: the error is a single-cycle pulse
    a_r8_err_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      src_err[s] |=> !src_err[s]);
    // R2: a grant needs a request sampled three cycles earlier
    a_r2_grant_latency: assert property (@(posedge clk) disable iff (!rst_n)
      src_grant[s] |-> $past(src_valid[s], 3));
  end
endmodule

bind xbar_age_arb xbar_age_arb_chk #(
  .NS(NS), .ND(ND), .DW(DW), .DSTW(DSTW), .SRCW(SRCW)
) i_chk (.*);

// File: tb/test_xbar_age_arb.sv
module test_xbar_age_arb;
  localparam int PERIOD = 10;
  localparam int NS = 8, ND = 9, DW = 64, DSTW = 4, SRCW = 3;

  typedef struct { int cyc; int dst; int src; logic [DW-1:0] data; } exp_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NS-1:0] src_valid;
  logic [NS*DSTW-1:0] src_dst;
  logic [NS*DW-1:0] src_data;
  logic [NS-1:0] src_grant, src_err;
  logic [ND-1:0] dst_valid;
  logic [ND*SRCW-1:0] dst_src;
  logic [ND*DW-1:0] dst_data;

  logic drv_v [NS];
  logic [DSTW-1:0] drv_d [NS];
  logic [DW-1:0] drv_p [NS];
  int err_cyc [NS];
  exp_t sb [$];
  int cyc = 0, checks = 0, errors = 0, gcyc = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always_comb begin
    for (int s = 0; s < NS; s++) begin
      src_valid[s] = drv_v[s];
      src_dst[s*DSTW +: DSTW] = drv_d[s];
      src_data[s*DW +: DW] = drv_p[s];
    end
  end

  xbar_age_arb i_xbar_age_arb (.*);

  task automatic req(input int s, input int d, input logic [DW-1:0] p);
    drv_v[s] = 1'b1; drv_d[s] = DSTW'(d); drv_p[s] = p;
  endtask

  task automatic expect_gnt(input int c, input int d, input int s, input logic [DW-1:0] p);
    exp_t e; e.cyc = c; e.dst = d; e.src = s; e.data = p; sb.push_back(e);
  endtask

  task automatic step();
    @(negedge clk); #1;
  endtask

  // monitor: scoreboard compare at the falling edge
  always @(negedge clk) if (rst_n && !done) begin
    logic [NS-1:0] seen;
    seen = '0;
    for (int d = 0; d < ND; d++) if (dst_valid[d]) begin
      int hit, s;
      s = int'(dst_src[d*SRCW +: SRCW]);
      seen[s] = 1'b1;
      hit = -1;
      foreach (sb[k]) if (hit < 0 && sb[k].cyc == cyc && sb[k].dst == d) hit = k;
      checks++;
      if (hit < 0) begin
        errors++; $display("FAIL R4/R7 unexpected grant cyc %0d dst %0d src %0d, expected none", cyc, d, s);
      end else begin
        if (sb[hit].src != s || sb[hit].data != dst_data[d*DW +: DW]) begin
          errors++; $display("FAIL R3/R5 dst %0d cyc %0d src %0d data %h, expected src %0d data %h",
                             d, cyc, s, dst_data[d*DW +: DW], sb[hit].src, sb[hit].data);
        end
        sb.delete(hit);
      end
    end
    for (int k = sb.size() - 1; k >= 0; k--) if (sb[k].cyc < cyc) begin
      checks++; errors++;
      $display("FAIL R2/R4 missing grant dst %0d src %0d due %0d, actual none at %0d", sb[k].dst, sb[k].src, sb[k].cyc, cyc);
      sb.delete(k);
    end
    if ((src_grant | seen) != '0) begin
      checks++;
      if (src_grant != seen) begin
        errors++; $display("FAIL R2 src_grant %b expected %b", src_grant, seen);
      end
    end
    for (int s = 0; s < NS; s++) begin
      if (src_err[s] || err_cyc[s] == cyc) begin
        checks++;
        if (src_err[s] != (err_cyc[s] == cyc)) begin
          errors++; $display("FAIL R8 src %0d cyc %0d err %b expected %b", s, cyc, src_err[s], err_cyc[s] == cyc);
        end
      end
      if (src_grant[s] || src_err[s]) drv_v[s] = 1'b0;
    end
    if (src_grant[5]) gcyc = cyc;
  end

  initial begin
    for (int s = 0; s < NS; s++) begin drv_v[s] = 0; drv_d[s] = '0; drv_p[s] = '0; err_cyc[s] = -1; end
    repeat (3) @(negedge clk);
    checks++;
    if (src_grant != 0 || src_err != 0 || dst_valid != 0) begin
      errors++; $display("FAIL R1 reset outputs %b %b %b expected 0", src_grant, src_err, dst_valid);
    end
    step(); rst_n = 1'b1;
    step();
    checks++;
    if (src_grant != 0 || src_err != 0 || dst_valid != 0) begin
      errors++; $display("FAIL R1 post-reset outputs %b %b %b expected 0", src_grant, src_err, dst_valid);
    end

    // R2, R3: single request to idle target
    req(2, 5, 64'hA5A5_0000_1111_2222); expect_gnt(cyc + 3, 5, 2, 64'hA5A5_0000_1111_2222);
    repeat (6) step();

    // R6: all sources to distinct targets
    for (int s = 0; s < NS; s++) begin
      req(s, (s + 3) % ND, 64'h100 + 64'(s)); expect_gnt(cyc + 3, (s + 3) % ND, s, 64'h100 + 64'(s));
    end
    repeat (6) step();

    // R5: same-cycle contention, ascending order
    req(6, 3, 64'h66); req(1, 3, 64'h11); req(4, 3, 64'h44);
    expect_gnt(cyc + 3, 3, 1, 64'h11); expect_gnt(cyc + 4, 3, 4, 64'h44); expect_gnt(cyc + 5, 3, 6, 64'h66);
    repeat (8) step();

    // R4: age beats source number
    req(7, 0, 64'h77); expect_gnt(cyc + 3, 0, 7, 64'h77);
    step();
    req(3, 0, 64'h33); req(0, 0, 64'h0F);
    expect_gnt(cyc + 3, 0, 0, 64'h0F); expect_gnt(cyc + 4, 0, 3, 64'h33);
    repeat (8) step();

    // R7: back-to-back from one source, top target index
    req(5, 8, 64'h5858); expect_gnt(cyc + 3, 8, 5, 64'h5858);
    repeat (4) step();
    checks++;
    if (gcyc != cyc - 1) begin
      errors++; $display("FAIL R7 grant cycle %0d expected %0d", gcyc, cyc - 1);
    end
    req(5, 1, 64'h5151); expect_gnt(cyc + 3, 1, 5, 64'h5151);
    repeat (6) step();

    // R8: out-of-range target indices
    req(4, 9, 64'hBAD0); err_cyc[4] = cyc + 1;
    req(2, 15, 64'hBAD1); err_cyc[2] = cyc + 1;
    repeat (6) step();
    req(4, 2, 64'h4242); expect_gnt(cyc + 3, 2, 4, 64'h4242);
    repeat (6) step();

    checks++;
    if (sb.size() != 0) begin
      errors++; $display("FAIL R2 %0d grants outstanding, expected 0", sb.size());
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(PERIOD * 20000);
    if (!done) begin
      done = 1; checks++; errors++;
      $display("FAIL R2 watchdog expired, expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule